// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz timebase into a periodic interrupt tick. The timebase arrives as a one-cycle strobe on the system clock, and every strobe advances a free-running 15-bit count. A 4-bit rate code picks a power-of-two period. A tick falls on each strobe after which the count is an exact multiple of that period. Ticks therefore stay locked to the free-running count. When the rate code changes, the next tick lands on the next multiple of the new period. It does not wait a whole new period from the moment of the change.

A divider-control field decides the state of the count. It can run, freeze where it stands, or be held cleared at zero. Ticks are only produced while at least one consumer wants them. A consumer is the periodic-interrupt enable, or the square-wave enable together with a square-wave output that is in use. Each tick yields a one-cycle periodic-flag pulse. It also yields an interrupt-request pulse when the periodic-interrupt enable is set, and a square-wave pulse when the square-wave enable is set. The flag register, interrupt aggregation and time-of-day counting are left to neighbouring blocks.

The control state machine has four states:
- `ST_HOLD`: count cleared, no ticks. This is the reset state.
- `ST_FREEZE`: count kept, no ticks.
- `ST_QUIET`: count runs, no ticks.
- `ST_ACTIVE`: count runs, ticks allowed.

Its transitions are evaluated every clock, from any state:
- `GO_HOLD` is taken when `div_ctrl[1:0]` is 2'b11.
- `GO_FREEZE` is taken when `div_ctrl` is 4, 5 or 6.
- `GO_QUIET` is taken when `div_ctrl` is 0 to 2 and no consumer is present.
- `GO_ACTIVE` is taken when `div_ctrl` is 0 to 2 and a consumer is present.

Top module: `periodic_tick_gen`

## Requirements
- R1: While `rst_n` is low, all three pulse outputs are low and the count is zero. After release with a code-3 rate and a consumer enabled, the first tick is on the 4th strobe.
- R2: For rate codes 3 to 15, the period is 2^(code-1) strobes. Any window of 2×period consecutive strobes holds exactly two ticks.
- R3: Rate code 1 gives a period of 128 strobes and rate code 2 gives 256 strobes.
- R4: Rate code 0 produces no ticks.
- R5: Ticks occur only while `pie_en` is set, or while both `sqw_en` and `sqw_used` are set. A change of these enables takes effect one clock later.
- R6: A tick occurs on a strobe after which the count is a multiple of the period. After a rate change, the first tick falls on the next multiple of the new period. A change made in the same cycle as a strobe already applies to that strobe.
- R7: Every tick raises `pf_pulse` for exactly one clock, in the cycle after the strobe's clock edge.
- R8: `irq_pulse` accompanies a tick only when `pie_en` was set at the strobe.
- R9: `sqw_pulse` accompanies a tick only when `sqw_en` was set at the strobe.
- R10: While `div_ctrl[1:0]` is 2'b11, the count is held at zero and no ticks occur. After release with a code-3 rate, the first tick is on the 4th strobe.
- R11: While `div_ctrl` is 4, 5 or 6, the count is frozen and no ticks occur. After release, counting resumes from the frozen value.
- R12: The count and the rate code act only on strobes. With no strobe there is no tick, and the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_strobe | input | 1 | One-cycle 32768 Hz timebase strobe |
| rate_code | input | 4 | Rate select; 0 off, 1 and 2 remapped, 3..15 give 2^(code-1) |
| div_ctrl | input | 3 | Divider control: 0..2 run, [1:0]=11 clear, 4..6 freeze |
| pie_en | input | 1 | Periodic-interrupt enable |
| sqw_en | input | 1 | Square-wave enable |
| sqw_used | input | 1 | Square-wave output is in use |
| pf_pulse | output | 1 | Periodic-flag pulse, one clock per tick |
| irq_pulse | output | 1 | Interrupt-request pulse for a tick while enabled |
| sqw_pulse | output | 1 | Square-wave pulse for a tick while enabled |

## Verification
Two things can land in the same cycle: a rate-code change and a strobe that sits on a boundary of the new period. The bench provokes this by driving a new code in the same cycle as the strobe that brings the count to 24. The count moves from a 16-strobe period to an 8-strobe one. A tick is expected on that very strobe, since 24 is a multiple of 8 but not of 16.

A second coincidence is the flag, interrupt and square-wave pulses firing together. This is judged by running windows with both enables set and requiring equal counts on all three outputs.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FREEZE = 2'd1,
        ST_QUIET  = 2'd2,
        ST_ACTIVE = 2'd3
    } div_state_t;

    // Shift amount (log2 of period) for a nonzero rate code.
    function automatic logic [3:0] rate_shift(input logic [3:0] code);
        logic [3:0] r;
        unique case (code)
            4'd1:    r = 4'd7;
            4'd2:    r = 4'd8;
            default: r = code - 4'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ptg_ctrl_fsm.sv
module ptg_ctrl_fsm
    import ptg_pkg::*;
#(
    parameter int DIVC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIVC_W-1:0] div_ctrl,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              sqw_used,
    output div_state_t        state_q,
    output logic              cnt_run,
    output logic              cnt_clear,
    output logic              tick_ok
);
    localparam logic [DIVC_W-1:0] RUN_MAX = DIVC_W'(2);

    logic       go_hold;
    logic       go_run;
    logic       consumer;
    div_state_t state_d;

    assign go_hold  = (div_ctrl[1:0] == 2'b11);
    assign go_run   = (div_ctrl <= RUN_MAX);
    assign consumer = pie_en | (sqw_en & sqw_used);

    // Next-state selection: every state may leave on any transition.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD, ST_FREEZE, ST_QUIET, ST_ACTIVE: begin
                if (go_hold)          state_d = ST_HOLD;
                else if (!go_run)     state_d = ST_FREEZE;
                else if (consumer)    state_d = ST_ACTIVE;
                else                  state_d = ST_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_run   = 1'b0;
        cnt_clear = 1'b0;
        tick_ok   = 1'b0;
        unique case (state_q)
            ST_HOLD:   cnt_clear = 1'b1;
            ST_FREEZE: ;
            ST_QUIET:  cnt_run   = 1'b1;
            ST_ACTIVE: begin
                cnt_run = 1'b1;
                tick_ok = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ptg_timebase.sv
module ptg_timebase #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             run,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear)          cnt_q <= '0;
        else if (run && strobe)  cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/ptg_rate_decode.sv
module ptg_rate_decode
    import ptg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 15
) (
    input  logic [CODE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  mask,
    output logic              code_on
);
    logic [3:0] shift;

    assign code_on = (rate_code != '0);
    assign shift   = rate_shift(4'(rate_code));

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (32'(shift) > i);
    end

endmodule

// File: rtl/ptg_pulse_out.sv
module ptg_pulse_out (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pie_en,
    input  logic sqw_en,
    output logic pf_pulse,
    output logic irq_pulse,
    output logic sqw_pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_pulse  <= 1'b0;
            irq_pulse <= 1'b0;
            sqw_pulse <= 1'b0;
        end else begin
            pf_pulse  <= tick;
            irq_pulse <= tick & pie_en;
            sqw_pulse <= tick & sqw_en;
        end
    end

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
    import ptg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int DIVC_W = 3,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_strobe,
    input  logic [CODE_W-1:0] rate_code,
    input  logic [DIVC_W-1:0] div_ctrl,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              sqw_used,
    output logic              pf_pulse,
    output logic              irq_pulse,
    output logic              sqw_pulse
);
    div_state_t       state_q;
    logic             cnt_run;
    logic             cnt_clear;
    logic             tick_ok;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] mask;
    logic             code_on;
    logic             tick;

    ptg_ctrl_fsm #(.DIVC_W(DIVC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ctrl  (div_ctrl),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .sqw_used  (sqw_used),
        .state_q   (state_q),
        .cnt_run   (cnt_run),
        .cnt_clear (cnt_clear),
        .tick_ok   (tick_ok)
    );

    ptg_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (tb_strobe),
        .run     (cnt_run),
        .clear   (cnt_clear),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    ptg_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .rate_code (rate_code),
        .mask      (mask),
        .code_on   (code_on)
    );

    // A tick lands where the advanced count hits a period multiple.
    assign tick = tb_strobe & tick_ok & code_on & ((cnt_nxt & mask) == '0);

    ptg_pulse_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .pf_pulse  (pf_pulse),
        .irq_pulse (irq_pulse),
        .sqw_pulse (sqw_pulse)
    );

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tb_strobe,
    input logic [CODE_W-1:0] rate_code,
    input logic              pie_en,
    input logic              sqw_en,
    input logic              pf_pulse,
    input logic              irq_pulse,
    input logic              sqw_pulse,
    input div_state_t        state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  mask
);
    AST_PF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |=> !pf_pulse); // R7
    AST_PF_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |-> $past(tb_strobe)); // R12
    AST_PF_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |-> ($past(rate_code) != '0)); // R4
    AST_PF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |-> ((cnt_q & $past(mask)) == '0)); // R6
    AST_PF_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse |-> ($past(state_q) == ST_ACTIVE)); // R5
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (pf_pulse && $past(pie_en))); // R8
    AST_SQW_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> (pf_pulse && $past(sqw_en))); // R9
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (cnt_q == '0)); // R10
    AST_FREEZE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREEZE) |=> $stable(cnt_q)); // R11

endmodule

bind periodic_tick_gen ptg_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_strobe (tb_strobe),
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .pf_pulse  (pf_pulse),
    .irq_pulse (irq_pulse),
    .sqw_pulse (sqw_pulse),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .mask      (mask)
);

// File: tb/periodic_tick_gen_bench.sv
`timescale 1ns/1ps
module periodic_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_strobe = 1'b0;
    logic [3:0] rate_code = 4'd3;
    logic [2:0] div_ctrl = 3'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       sqw_used = 1'b0;
    logic       pf_pulse, irq_pulse, sqw_pulse;

    int checks = 0;
    int failures = 0;
    int pf_n = 0, irq_n = 0, sqw_n = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    periodic_tick_gen u_periodic_tick_gen (
        .clk(clk), .rst_n(rst_n), .tb_strobe(tb_strobe), .rate_code(rate_code),
        .div_ctrl(div_ctrl), .pie_en(pie_en), .sqw_en(sqw_en), .sqw_used(sqw_used),
        .pf_pulse(pf_pulse), .irq_pulse(irq_pulse), .sqw_pulse(sqw_pulse)
    );

    always @(negedge clk) begin
        if (pf_pulse)  pf_n++;
        if (irq_pulse) irq_n++;
        if (sqw_pulse) sqw_n++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        @(posedge clk); #1;
        pf_n = 0; irq_n = 0; sqw_n = 0;
    endtask

    // n consecutive strobes, then let the last pulse drain.
    task automatic run_window(input int n);
        clear_counts();
        tb_strobe = 1'b1;
        repeat (n) @(posedge clk);
        #1 tb_strobe = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_once(output bit got);
        @(posedge clk); #1 tb_strobe = 1'b1;
        @(posedge clk); #1 tb_strobe = 1'b0;
        @(negedge clk);
        got = pf_pulse;
    endtask

    // Returns how many strobes it takes to reach the next tick (max lim).
    task automatic strobes_to_tick(input int lim, output int n);
        bit g;
        n = 0;
        for (int k = 1; k <= lim; k++) begin
            strobe_once(g);
            if (g) begin n = k; break; end
        end
    endtask

    task automatic zero_count();
        div_ctrl = 3'b011; idle(3);
        div_ctrl = 3'b000; idle(3);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "pf in reset", pf_pulse, 0);
        check("R1", "irq in reset", irq_pulse, 0);
        check("R1", "sqw in reset", sqw_pulse, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        pie_en = 1'b1; rate_code = 4'd3; idle(3);
        begin
            int n;
            strobes_to_tick(10, n);
            check("R1", "first tick strobe after reset", n, 4);
        end
    endtask

    task automatic t_rates();
        pie_en = 1'b1; sqw_en = 1'b0; div_ctrl = 3'd0; idle(2);
        for (int c = 0; c < 16; c++) begin
            int p;
            rate_code = 4'(c); idle(1);
            if (c == 0) begin
                run_window(64);
                check("R4", "ticks for code 0", pf_n, 0);
            end else begin
                p = (c == 1) ? 128 : (c == 2) ? 256 : (1 << (c - 1));
                run_window(2 * p);
                if (c <= 2) check("R3", $sformatf("ticks code %0d", c), pf_n, 2);
                else        check("R2", $sformatf("ticks code %0d", c), pf_n, 2);
            end
        end
    endtask

    task automatic t_gating();
        rate_code = 4'd3;
        pie_en = 1'b0; sqw_en = 1'b1; sqw_used = 1'b0; idle(2);
        run_window(64);
        check("R5", "pf with no consumer", pf_n, 0);
        check("R9", "sqw with no consumer", sqw_n, 0);
        pie_en = 1'b1; sqw_en = 1'b0; idle(2);
        run_window(64);
        check("R5", "pf with pie only", pf_n, 16);
        check("R8", "irq with pie only", irq_n, 16);
        check("R9", "sqw with pie only", sqw_n, 0);
        pie_en = 1'b0; sqw_en = 1'b1; sqw_used = 1'b1; idle(2);
        run_window(64);
        check("R5", "pf with sqw consumer", pf_n, 16);
        check("R8", "irq with pie off", irq_n, 0);
        check("R9", "sqw with sqw on", sqw_n, 16);
        pie_en = 1'b1; idle(2);
        run_window(64);
        check("R7", "pf with both", pf_n, 16);
        check("R8", "irq with both", irq_n, 16);
        check("R9", "sqw with both", sqw_n, 16);
        sqw_en = 1'b0; sqw_used = 1'b0; idle(2);
    endtask

    task automatic t_align();
        int n;
        bit g;
        pie_en = 1'b1; rate_code = 4'd4; zero_count();
        strobes_to_tick(5, n);
        check("R6", "no tick in strobes 1..5 at period 8", n, 0);
        rate_code = 4'd3;
        strobes_to_tick(8, n);
        check("R6", "strobes to tick after 8->4 switch", n, 3);
        rate_code = 4'd5;
        strobes_to_tick(16, n);
        check("R6", "strobes to tick after 4->16 switch", n, 8);
        strobes_to_tick(7, n);
        check("R6", "no tick at count 17..23", n, 0);
        // change code in the same cycle as the strobe that reaches 24
        @(posedge clk); #1 tb_strobe = 1'b1; rate_code = 4'd4;
        @(posedge clk); #1 tb_strobe = 1'b0;
        @(negedge clk);
        check("R6", "tick on coincident code change", pf_pulse, 1);
        @(negedge clk);
        check("R7", "pf width one cycle", pf_pulse, 0);
        strobe_once(g);
    endtask

    task automatic t_divider();
        int n;
        bit g;
        pie_en = 1'b1; rate_code = 4'd3;
        div_ctrl = 3'b011; idle(3);
        run_window(300);
        check("R10", "ticks while held", pf_n, 0);
        div_ctrl = 3'b000; idle(3);
        strobes_to_tick(10, n);
        check("R10", "first tick after hold release", n, 4);
        div_ctrl = 3'b100; idle(3);
        run_window(10);
        check("R11", "ticks while frozen", pf_n, 0);
        div_ctrl = 3'b000; idle(3);
        strobes_to_tick(10, n);
        check("R11", "resume from frozen count", n, 4);
        strobe_once(g);
        clear_counts();
        idle(100);
        @(negedge clk);
        check("R12", "ticks with no strobe", pf_n, 0);
        strobes_to_tick(10, n);
        check("R12", "count kept without strobes", n, 3);
    endtask

    initial begin
        t_reset();
        t_rates();
        t_gating();
        t_align();
        t_divider();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule